// File: doc/BRIEF.md
# Pairwise Tamper Checker for Block-Truncation Compressed Words

This block sits at the receiving end of a link that carries block-truncation compressed image data with verification bits hidden inside the bitmaps. Each block is one 32-bit word: a 16-bit bitmap in the upper half, then the low level byte, then the high level byte. The bitmap is divided from its top bit down into two 7-bit carrier fields and one 2-bit field. The two carrier fields hold the hidden data. The 2-bit field and the two level bytes form an 18-bit protected value, which is the low 18 bits of the word.

Blocks are checked in pairs, and the sequencer upstream supplies the pairs from the keyed pairing map. For each pair the checker sends the protected value of each word in turn to an external keyed hash. It compares each 6-bit hash result with the 6 bits recovered from the other word of the pair. If either direction disagrees, it reports the pair as tampered and gives both block indices. Because each word's check value is stored in its partner, swapping whole words between pairs is also caught. A sticky flag records whether any pair in the current frame has failed.

Top module: `tamper_check`

## Requirements
- R1: After a pair is accepted, `hash_data` holds bits [17:0] of word A for one cycle and then bits [17:0] of word B for the next cycle. The external hash returns its 6-bit result combinationally on `hash_value`.
- R2: The 6 recovered bits for a word are {s1, s2}. s1 is the syndrome of bitmap bits [31:25] and s2 is the syndrome of bits [24:18]. A syndrome is the XOR of the 3-bit values j (1 to 7) over every set bit at field position j-1, counted from the field's LSB.
- R3: `res_tamper` is 1 exactly when hash(A) differs from the bits recovered from word B, or hash(B) differs from the bits recovered from word A. It is 0 whenever `res_valid` is 0.
- R4: With each result, `res_idx_a` and `res_idx_b` give the two block indices that were accepted with that pair, so the verdict applies to both blocks.
- R5: `res_valid` pulses for exactly one cycle, three clock edges after the edge that accepted the pair.
- R6: A pair is accepted on an edge where `pair_valid` and `pair_ready` are both 1. `pair_ready` is 0 for the two cycles after an accept, and `pair_valid` has no effect on the results while `pair_ready` is 0.
- R7: `frame_tamper` becomes 1 together with any result that has `res_tamper` set. It stays 1 until an edge with `frame_start` set clears it. If a tampered result lands on that same edge, the flag remains 1.
- R8: Reset is synchronous and active high. After reset, `pair_ready` is 1 and `res_valid`, `res_tamper`, `frame_tamper` and `hash_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears the frame tamper flag |
| pair_valid | input | 1 | A pair is offered |
| pair_ready | output | 1 | Checker can accept a pair |
| pair_idx_a | input | IDX_W | Index of block A |
| pair_idx_b | input | IDX_W | Index of block B |
| pair_word_a | input | 32 | Received word of block A |
| pair_word_b | input | 32 | Received word of block B |
| hash_data | output | 18 | Protected value sent to the keyed hash |
| hash_value | input | 6 | Keyed hash of `hash_data` |
| res_valid | output | 1 | Verdict pulse |
| res_tamper | output | 1 | The pair failed its check |
| res_idx_a | output | IDX_W | Index of block A for this verdict |
| res_idx_b | output | IDX_W | Index of block B for this verdict |
| frame_tamper | output | 1 | Sticky flag: some pair in this frame failed |

## Verification
Assertions check the handshake timing on every cycle: the order of the hash requests, the fixed three-edge latency, the single-cycle verdict pulse, the busy window and the index pass-through. They also check the set, hold and clear rules of the frame flag. Whether a given verdict is correct depends on the keyed hash and the embedding, so only the bench scenarios can show it. These scenarios cover clean frames with no false alarms, single-bit flips in carrier and protected fields, whole-word swaps between pairs, and a clear of the frame flag that coincides with a result.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HASHA = 2'd1,
    ST_HASHB = 2'd2
  } chk_state_t;

  function automatic int carrier_width(input int seg_w);
    return (1 << seg_w) - 1;
  endfunction
endpackage

// File: rtl/tamper_syndrome.sv
module tamper_syndrome #(
  parameter int SEG_W  = 3,
  localparam int PART_W = (1 << SEG_W) - 1
) (
  input  logic [PART_W-1:0] field,
  output logic [SEG_W-1:0]  syn
);
  always_comb begin
    syn = '0;
    for (int j = 1; j <= PART_W; j++) begin
      if (field[j-1]) syn = syn ^ SEG_W'(j);
    end
  end
endmodule

// File: rtl/tamper_extract.sv
module tamper_extract #(
  parameter int SEG_W = 3,
  parameter int NSEG  = 2,
  localparam int PART_W = (1 << SEG_W) - 1,
  localparam int EMB_W  = NSEG * PART_W,
  localparam int VER_W  = NSEG * SEG_W
) (
  input  logic [EMB_W-1:0] carriers,
  output logic [VER_W-1:0] ver
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    tamper_syndrome #(.SEG_W(SEG_W)) u_syn (
      .field (carriers[EMB_W-1-g*PART_W -: PART_W]),
      .syn   (ver[VER_W-1-g*SEG_W -: SEG_W])
    );
  end
endmodule

// File: rtl/tamper_check.sv
module tamper_check #(
  parameter int IDX_W = 14,
  parameter int SEG_W = 3,
  parameter int NSEG  = 2,
  parameter int P3_W  = 2,
  parameter int LVL_W = 8,
  localparam int PART_W = (1 << SEG_W) - 1,
  localparam int EMB_W  = NSEG * PART_W,
  localparam int HIN_W  = P3_W + 2 * LVL_W,
  localparam int WORD_W = EMB_W + HIN_W,
  localparam int VER_W  = NSEG * SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              pair_valid,
  output logic              pair_ready,
  input  logic [IDX_W-1:0]  pair_idx_a,
  input  logic [IDX_W-1:0]  pair_idx_b,
  input  logic [WORD_W-1:0] pair_word_a,
  input  logic [WORD_W-1:0] pair_word_b,
  output logic [HIN_W-1:0]  hash_data,
  input  logic [VER_W-1:0]  hash_value,
  output logic              res_valid,
  output logic              res_tamper,
  output logic [IDX_W-1:0]  res_idx_a,
  output logic [IDX_W-1:0]  res_idx_b,
  output logic              frame_tamper
);
  import tamper_pkg::*;

  chk_state_t        state;
  logic [EMB_W-1:0]  emb_a, emb_b;
  logic [HIN_W-1:0]  prot_b;
  logic [IDX_W-1:0]  idx_a, idx_b;
  logic              mis_a;
  logic [EMB_W-1:0]  partner;
  logic [VER_W-1:0]  recovered;
  logic              lane_bad;
  logic              pair_bad;

  assign pair_ready = (state == ST_IDLE);
  assign partner    = (state == ST_HASHA) ? emb_b : emb_a;

  tamper_extract #(.SEG_W(SEG_W), .NSEG(NSEG)) u_extract (
    .carriers (partner),
    .ver      (recovered)
  );

  assign lane_bad = (hash_value != recovered);
  assign pair_bad = mis_a | lane_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      emb_a        <= '0;
      emb_b        <= '0;
      prot_b       <= '0;
      idx_a        <= '0;
      idx_b        <= '0;
      mis_a        <= 1'b0;
      hash_data    <= '0;
      res_valid    <= 1'b0;
      res_tamper   <= 1'b0;
      res_idx_a    <= '0;
      res_idx_b    <= '0;
      frame_tamper <= 1'b0;
    end else begin
      res_valid  <= 1'b0;
      res_tamper <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (pair_valid) begin
            emb_a     <= pair_word_a[WORD_W-1 -: EMB_W];
            emb_b     <= pair_word_b[WORD_W-1 -: EMB_W];
            prot_b    <= pair_word_b[HIN_W-1:0];
            idx_a     <= pair_idx_a;
            idx_b     <= pair_idx_b;
            hash_data <= pair_word_a[HIN_W-1:0];
            state     <= ST_HASHA;
          end
        end
        ST_HASHA: begin
          mis_a     <= lane_bad;
          hash_data <= prot_b;
          state     <= ST_HASHB;
        end
        ST_HASHB: begin
          res_valid  <= 1'b1;
          res_tamper <= pair_bad;
          res_idx_a  <= idx_a;
          res_idx_b  <= idx_b;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      frame_tamper <= (frame_start ? 1'b0 : frame_tamper)
                    | ((state == ST_HASHB) & pair_bad);
    end
  end
endmodule

// File: rtl/tamper_check_sva.sv
module tamper_check_sva #(
  parameter int IDX_W = 14,
  parameter int HIN_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             pair_valid,
  input logic             pair_ready,
  input logic [IDX_W-1:0] pair_idx_a,
  input logic [IDX_W-1:0] pair_idx_b,
  input logic [HIN_W-1:0] prot_a,
  input logic [HIN_W-1:0] prot_b,
  input logic [HIN_W-1:0] hash_data,
  input logic             res_valid,
  input logic             res_tamper,
  input logic [IDX_W-1:0] res_idx_a,
  input logic [IDX_W-1:0] res_idx_b,
  input logic             frame_tamper
);
  logic accept;
  assign accept = pair_valid && pair_ready;

  AST_HASH_A_FIRST: assert property (@(posedge clk) disable iff (rst)
    accept |=> hash_data == $past(prot_a)); // R1
  AST_HASH_B_SECOND: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##2 hash_data == $past(prot_b, 2)); // R1
  AST_NO_FLAG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_tamper); // R3
  AST_IDX_PASS: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##3 (res_idx_a == $past(pair_idx_a, 3) && res_idx_b == $past(pair_idx_b, 3))); // R4
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##3 res_valid); // R5
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R5
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    accept |=> !pair_ready ##1 !pair_ready); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_tamper |-> frame_tamper); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    frame_tamper && !frame_start |=> frame_tamper); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> frame_tamper == (res_valid && res_tamper)); // R7
endmodule

bind tamper_check tamper_check_sva #(.IDX_W(IDX_W), .HIN_W(HIN_W)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .frame_start  (frame_start),
  .pair_valid   (pair_valid),
  .pair_ready   (pair_ready),
  .pair_idx_a   (pair_idx_a),
  .pair_idx_b   (pair_idx_b),
  .prot_a       (pair_word_a[HIN_W-1:0]),
  .prot_b       (pair_word_b[HIN_W-1:0]),
  .hash_data    (hash_data),
  .res_valid    (res_valid),
  .res_tamper   (res_tamper),
  .res_idx_a    (res_idx_a),
  .res_idx_b    (res_idx_b),
  .frame_tamper (frame_tamper)
);

// File: tb/tamper_check_tb.sv
module tamper_check_tb;
  localparam int IDX_W = 14;
  localparam int NBLK  = 16;
  localparam int NPAIR = NBLK / 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              frame_start = 1'b0;
  logic              pair_valid = 1'b0;
  logic              pair_ready;
  logic [IDX_W-1:0]  pair_idx_a = '0, pair_idx_b = '0;
  logic [31:0]       pair_word_a = '0, pair_word_b = '0;
  logic [17:0]       hash_data;
  logic [5:0]        hash_value;
  logic              res_valid, res_tamper, frame_tamper;
  logic [IDX_W-1:0]  res_idx_a, res_idx_b;

  int checks = 0;
  int fails  = 0;
  logic [31:0] words [NBLK];
  int          pa [NPAIR];
  int          pb [NPAIR];
  logic        run_or;

  always #4 clk = ~clk;

  function automatic logic [5:0] kh(input logic [17:0] d);
    logic [31:0] x;
    x = {d, 14'h2b5} ^ 32'hC3A5_1F07;
    x = x * 32'h9E37_79B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EB_CA6B;
    x = x ^ (x >> 13);
    return x[31:26];
  endfunction

  assign hash_value = kh(hash_data);

  tamper_check #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .pair_valid(pair_valid), .pair_ready(pair_ready),
    .pair_idx_a(pair_idx_a), .pair_idx_b(pair_idx_b),
    .pair_word_a(pair_word_a), .pair_word_b(pair_word_b),
    .hash_data(hash_data), .hash_value(hash_value),
    .res_valid(res_valid), .res_tamper(res_tamper),
    .res_idx_a(res_idx_a), .res_idx_b(res_idx_b),
    .frame_tamper(frame_tamper)
  );

  function automatic logic [2:0] syn7(input logic [6:0] f);
    logic [2:0] s = 3'd0;
    for (int j = 0; j < 7; j++) if (f[j]) s = s ^ 3'(j + 1);
    return s;
  endfunction

  function automatic logic [6:0] hide(input logic [6:0] f, input logic [2:0] m);
    logic [2:0] d = syn7(f) ^ m;
    logic [6:0] r = f;
    if (d != 3'd0) r[d - 3'd1] = ~r[d - 3'd1];
    return r;
  endfunction

  function automatic logic [5:0] recov(input logic [31:0] w);
    return {syn7(w[31:25]), syn7(w[24:18])};
  endfunction

  function automatic logic expect_bad(input logic [31:0] wa, input logic [31:0] wb);
    return (kh(wa[17:0]) != recov(wb)) || (kh(wb[17:0]) != recov(wa));
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic make_frame();
    int perm [NBLK];
    for (int i = 0; i < NBLK; i++) begin
      perm[i]  = i;
      words[i] = $urandom;
    end
    for (int i = NBLK - 1; i > 0; i--) begin
      int k = $urandom_range(i, 0);
      int t = perm[i];
      perm[i] = perm[k];
      perm[k] = t;
    end
    for (int p = 0; p < NPAIR; p++) begin
      logic [5:0] va, vb;
      pa[p] = perm[p];
      pb[p] = perm[p + NPAIR];
      va = kh(words[pa[p]][17:0]);
      vb = kh(words[pb[p]][17:0]);
      words[pb[p]][31:25] = hide(words[pb[p]][31:25], va[5:3]);
      words[pb[p]][24:18] = hide(words[pb[p]][24:18], va[2:0]);
      words[pa[p]][31:25] = hide(words[pa[p]][31:25], vb[5:3]);
      words[pa[p]][24:18] = hide(words[pa[p]][24:18], vb[2:0]);
    end
  endtask

  task automatic send_pair(input int a, input int b, input logic clr_at_result);
    logic exp;
    exp = expect_bad(words[a], words[b]);
    @(negedge clk);
    while (!pair_ready) @(negedge clk);
    pair_valid  = 1'b1;
    pair_idx_a  = IDX_W'(a);
    pair_idx_b  = IDX_W'(b);
    pair_word_a = words[a];
    pair_word_b = words[b];
    @(negedge clk);
    chk(pair_ready == 1'b0, "R6 busy after accept", 32'(pair_ready), 32'd0);
    chk(hash_data == words[a][17:0], "R1 first hash request", 32'(hash_data), 32'(words[a][17:0]));
    pair_idx_a  = IDX_W'(a ^ 5);
    pair_word_a = ~words[a];
    pair_word_b = 32'h0;
    @(negedge clk);
    pair_valid = 1'b0;
    chk(hash_data == words[b][17:0], "R1 second hash request", 32'(hash_data), 32'(words[b][17:0]));
    chk(res_valid == 1'b0, "R5 no early result", 32'(res_valid), 32'd0);
    if (clr_at_result) frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(res_valid == 1'b1, "R5 result after three edges", 32'(res_valid), 32'd1);
    chk(res_tamper == exp, "R2 R3 pair verdict", 32'(res_tamper), 32'(exp));
    chk(res_idx_a == IDX_W'(a) && res_idx_b == IDX_W'(b), "R4 pair indices",
        32'({res_idx_a, res_idx_b}), 32'({IDX_W'(a), IDX_W'(b)}));
    run_or = clr_at_result ? exp : (run_or | exp);
    chk(frame_tamper == run_or, "R7 frame flag", 32'(frame_tamper), 32'(run_or));
    @(negedge clk);
    chk(res_valid == 1'b0 && res_tamper == 1'b0, "R5 R6 single pulse, ignored offer",
        32'({res_valid, res_tamper}), 32'd0);
  endtask

  task automatic run_frame(input int clr_pair);
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    run_or = 1'b0;
    chk(frame_tamper == 1'b0, "R7 flag cleared by frame_start", 32'(frame_tamper), 32'd0);
    for (int p = 0; p < NPAIR; p++) send_pair(pa[p], pb[p], p == clr_pair);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(pair_ready == 1'b1 && res_valid == 1'b0 && res_tamper == 1'b0 &&
        frame_tamper == 1'b0 && hash_data == 18'd0, "R8 reset state",
        32'({pair_ready, res_valid, res_tamper, frame_tamper}), 32'h8);

    // clean frames: no false alarms expected
    for (int f = 0; f < 2; f++) begin
      make_frame();
      run_frame(-1);
      chk(frame_tamper == 1'b0, "R3 clean frame has no alarm", 32'(frame_tamper), 32'd0);
    end

    // random single-bit flips in three blocks
    for (int f = 0; f < 3; f++) begin
      make_frame();
      for (int k = 0; k < 3; k++) begin
        int blk = $urandom_range(NBLK - 1, 0);
        int bit_i = $urandom_range(31, 0);
        words[blk][bit_i] = ~words[blk][bit_i];
      end
      run_frame(-1);
    end

    // directed: carrier flip, always caught; and protected-field flip
    make_frame();
    words[pa[0]][27] = ~words[pa[0]][27];
    words[pb[3]][5]  = ~words[pb[3]][5];
    chk(expect_bad(words[pa[0]], words[pb[0]]) == 1'b1, "R2 carrier flip changes syndrome",
        32'(expect_bad(words[pa[0]], words[pb[0]])), 32'd1);
    run_frame(-1);

    // whole-word swap between two pairs
    make_frame();
    begin
      logic [31:0] t;
      t = words[pa[1]];
      words[pa[1]] = words[pa[5]];
      words[pa[5]] = t;
    end
    run_frame(-1);

    // clear coinciding with a tampered result
    make_frame();
    words[pb[4]][20] = ~words[pb[4]][20];
    run_frame(4);
    run_frame(-1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule